// File: doc/BRIEF.md
# Data Memory Access Unit with Fault Reporting

This unit carries out the data-side memory accesses of a 32-bit RISC-V style core. A request names a direction (load or store), a three-bit width code taken from the instruction's funct3 field, an effective byte address and, for stores, the store data. The unit checks that the width code is legal for that direction and that the address is aligned to the access size. It then sends the access to one of two places. Addresses inside a local RAM window go to an on-chip RAM that answers in a fixed number of cycles. All other addresses go to an external request/response port, whose response can carry an error.

Each accepted request produces exactly one registered response. The response holds either the result or a single exception cause. The checks run in a fixed order. An illegal width code is reported first, then a misaligned address, and only then an access fault. When a load reads a byte or halfword, the unit picks the lane out of the 32-bit word and sign- or zero-extends it. A store writes only the byte lanes it covers.

The unit also publishes the core's boot address, which is the base of the RAM window plus 0x40.

Top module: `lsu_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `ext_req_valid` is 0. `boot_pc` always equals RAM_BASE + 0x40.
- R2: Some width codes are illegal. For loads these are funct3 = 3'b011, 3'b110 and 3'b111. For stores they are any funct3 above 3'b010. An illegal code gives cause 2, and memory is left unchanged.
- R3: The access size is 1 << funct3[1:0] bytes. An address is misaligned when it has any bit set below that size. A misaligned load gives cause 4 and a misaligned store gives cause 6, and no memory is written.
- R4: The cause is chosen in fixed priority order. Illegal comes before misaligned, and misaligned comes before access fault. A request rejected as illegal or misaligned issues no external request.
- R5: Load extraction works as follows. funct3 000 and 001 sign-extend the byte at lane addr[1:0] and the halfword at lane addr[1], respectively. funct3 100 and 101 zero-extend them. funct3 010 returns the whole word.
- R6: A byte store replaces byte lane addr[1:0]. A halfword store replaces halfword lane addr[1]. A word store replaces the whole word. All other bits of the word are kept.
- R7: An address in [RAM_BASE, RAM_BASE + 4*RAM_WORDS) always goes to the local RAM and never raises `ext_req_valid`. A RAM store responds in the cycle after acceptance, and a RAM load responds one cycle later than that.
- R8: Addresses outside the window go to the external port. `ext_req_valid` holds with stable fields until `ext_req_ready`. An error response gives cause 5 for a load and cause 7 for a store. A response without error completes the access.
- R9: `req_ready` is low while an access is in flight. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R10: When a response carries an exception, or answers a store, `rsp_rdata` is 0 and `rsp_cause` is 0 unless `rsp_exc` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Width and extension code |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Extended load result |
| rsp_exc | output | 1 | Response carries an exception |
| rsp_cause | output | 4 | Exception cause code |
| boot_pc | output | 32 | Core reset vector |
| ext_req_valid | output | 1 | External request valid |
| ext_req_ready | input | 1 | External request accepted |
| ext_req_write | output | 1 | External request is a write |
| ext_req_addr | output | 32 | Word-aligned external address |
| ext_req_wdata | output | 32 | Lane-replicated write data |
| ext_req_be | output | 4 | Byte lanes covered by the access |
| ext_rsp_valid | input | 1 | External response valid |
| ext_rsp_rdata | input | 32 | External read word |
| ext_rsp_err | input | 1 | External access refused |

## Verification
The first port to show an internal fault is the response: the wrong cause, a wrong extension of a loaded lane, or a missing or doubled `rsp_valid` pulse, seen one or two cycles after acceptance. A routing decision that goes wrong shows at `ext_req_valid` in the cycle after acceptance. A lane-merge error shows only when the word is next loaded, so each store is followed directly by a read-back. A stuck state shows as `req_ready` staying low.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 4;
  localparam int LANES   = XLEN / 8;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_MIS  = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FLT  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MIS  = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FLT  = 4'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RAM_RD,
    ST_EXT_REQ,
    ST_EXT_RSP
  } lsu_state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter logic [31:0] RAM_BASE  = 32'h0,
  parameter int          RAM_WORDS = 256,
  parameter int          AW        = $clog2(RAM_WORDS)
) (
  input  logic            store,
  input  logic [2:0]      funct3,
  input  logic [XLEN-1:0] addr,
  output logic            illegal,
  output logic            misal,
  output logic            ram_hit,
  output logic [AW-1:0]   ram_idx
);
  localparam logic [XLEN:0] WIN_LO = {1'b0, RAM_BASE};
  localparam logic [XLEN:0] WIN_HI = {1'b0, RAM_BASE} + (XLEN+1)'(RAM_WORDS * 4);

  logic [1:0] size_mask;

  always_comb begin
    if (store) illegal = (funct3 > 3'b010);
    else       illegal = (funct3 == 3'b011) || (funct3 > 3'b101);
    case (funct3[1:0])
      2'b00:   size_mask = 2'b00;
      2'b01:   size_mask = 2'b01;
      default: size_mask = 2'b11;
    endcase
    misal   = |(addr[1:0] & size_mask);
    ram_hit = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
    ram_idx = AW'((addr - RAM_BASE) >> 2);
  end
endmodule

// File: rtl/lsu_st_merge.sv
module lsu_st_merge
  import lsu_pkg::*;
(
  input  logic [2:0]       funct3,
  input  logic [1:0]       lo,
  input  logic [XLEN-1:0]  wdata,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  wlanes
);
  always_comb begin
    case (funct3[1:0])
      2'b00: begin
        be     = 4'b0001 << lo;
        wlanes = {4{wdata[7:0]}};
      end
      2'b01: begin
        be     = lo[1] ? 4'b1100 : 4'b0011;
        wlanes = {2{wdata[15:0]}};
      end
      default: begin
        be     = 4'b1111;
        wlanes = wdata;
      end
    endcase
  end
endmodule

// File: rtl/lsu_ld_extract.sv
module lsu_ld_extract
  import lsu_pkg::*;
(
  input  logic [2:0]      funct3,
  input  logic [1:0]      lo,
  input  logic [XLEN-1:0] word,
  output logic [XLEN-1:0] result
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = 8'(word >> {lo, 3'b000});
    half_sel = lo[1] ? word[31:16] : word[15:0];
    case (funct3[1:0])
      2'b00:   result = funct3[2] ? {24'd0, byte_sel} : {{24{byte_sel[7]}}, byte_sel};
      2'b01:   result = funct3[2] ? {16'd0, half_sel} : {{16{half_sel[15]}}, half_sel};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_ram.sv
module lsu_ram
  import lsu_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    idx,
  input  logic [XLEN-1:0]  wdata,
  output logic [XLEN-1:0]  q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q_b;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) mem[idx] <= wdata[g*8 +: 8];
        q_b <= mem[idx];
      end
    end
    assign q[g*8 +: 8] = q_b;
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter logic [31:0] RAM_BASE  = 32'h0,
  parameter int          RAM_WORDS = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_store,
  input  logic [2:0]   req_funct3,
  input  logic [31:0]  req_addr,
  input  logic [31:0]  req_wdata,
  output logic         rsp_valid,
  output logic [31:0]  rsp_rdata,
  output logic         rsp_exc,
  output logic [3:0]   rsp_cause,
  output logic [31:0]  boot_pc,
  output logic         ext_req_valid,
  input  logic         ext_req_ready,
  output logic         ext_req_write,
  output logic [31:0]  ext_req_addr,
  output logic [31:0]  ext_req_wdata,
  output logic [3:0]   ext_req_be,
  input  logic         ext_rsp_valid,
  input  logic [31:0]  ext_rsp_rdata,
  input  logic         ext_rsp_err
);
  localparam int AW = $clog2(RAM_WORDS);

  lsu_state_e state;
  logic       op_store;
  logic [2:0] op_f3;
  logic [1:0] op_lo;

  logic            dec_illegal, dec_misal, dec_hit;
  logic [AW-1:0]   dec_idx;
  logic [LANES-1:0] st_be;
  logic [XLEN-1:0] st_lanes, ram_q, ld_word, ld_data;
  logic            accept, ram_en;

  assign boot_pc   = RAM_BASE + 32'h40;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ram_en    = accept && !dec_illegal && !dec_misal && dec_hit;
  assign ld_word   = (state == ST_RAM_RD) ? ram_q : ext_rsp_rdata;

  lsu_decode #(.RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS), .AW(AW)) u_decode (
    .store   (req_store),
    .funct3  (req_funct3),
    .addr    (req_addr),
    .illegal (dec_illegal),
    .misal   (dec_misal),
    .ram_hit (dec_hit),
    .ram_idx (dec_idx)
  );

  lsu_st_merge u_merge (
    .funct3 (req_funct3),
    .lo     (req_addr[1:0]),
    .wdata  (req_wdata),
    .be     (st_be),
    .wlanes (st_lanes)
  );

  lsu_ram #(.WORDS(RAM_WORDS), .AW(AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (req_store),
    .be    (st_be),
    .idx   (dec_idx),
    .wdata (st_lanes),
    .q     (ram_q)
  );

  lsu_ld_extract u_extract (
    .funct3 (op_f3),
    .lo     (op_lo),
    .word   (ld_word),
    .result (ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      op_store      <= 1'b0;
      op_f3         <= 3'd0;
      op_lo         <= 2'd0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_exc       <= 1'b0;
      rsp_cause     <= CAUSE_NONE;
      ext_req_valid <= 1'b0;
      ext_req_write <= 1'b0;
      ext_req_addr  <= '0;
      ext_req_wdata <= '0;
      ext_req_be    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_store <= req_store;
            op_f3    <= req_funct3;
            op_lo    <= req_addr[1:0];
            if (dec_illegal) begin
              rsp_valid <= 1'b1;
              rsp_exc   <= 1'b1;
              rsp_cause <= CAUSE_ILLEGAL;
              rsp_rdata <= '0;
            end else if (dec_misal) begin
              rsp_valid <= 1'b1;
              rsp_exc   <= 1'b1;
              rsp_cause <= req_store ? CAUSE_ST_MIS : CAUSE_LD_MIS;
              rsp_rdata <= '0;
            end else if (dec_hit) begin
              if (req_store) begin
                rsp_valid <= 1'b1;
                rsp_exc   <= 1'b0;
                rsp_cause <= CAUSE_NONE;
                rsp_rdata <= '0;
              end else begin
                state <= ST_RAM_RD;
              end
            end else begin
              ext_req_valid <= 1'b1;
              ext_req_write <= req_store;
              ext_req_addr  <= {req_addr[XLEN-1:2], 2'b00};
              ext_req_wdata <= st_lanes;
              ext_req_be    <= st_be;
              state         <= ST_EXT_REQ;
            end
          end
        end
        ST_RAM_RD: begin
          rsp_valid <= 1'b1;
          rsp_exc   <= 1'b0;
          rsp_cause <= CAUSE_NONE;
          rsp_rdata <= ld_data;
          state     <= ST_IDLE;
        end
        ST_EXT_REQ: begin
          if (ext_req_ready) begin
            ext_req_valid <= 1'b0;
            state         <= ST_EXT_RSP;
          end
        end
        ST_EXT_RSP: begin
          if (ext_rsp_valid) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
            if (ext_rsp_err) begin
              rsp_exc   <= 1'b1;
              rsp_cause <= op_store ? CAUSE_ST_FLT : CAUSE_LD_FLT;
              rsp_rdata <= '0;
            end else begin
              rsp_exc   <= 1'b0;
              rsp_cause <= CAUSE_NONE;
              rsp_rdata <= op_store ? '0 : ld_data;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_unit_sva.sv
module lsu_unit_sva #(
  parameter logic [31:0] RAM_BASE  = 32'h0,
  parameter int          RAM_WORDS = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_store,
  input logic [2:0]  req_funct3,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_exc,
  input logic [3:0]  rsp_cause,
  input logic        ext_req_valid,
  input logic        ext_req_ready,
  input logic        ext_req_write,
  input logic [31:0] ext_req_addr
);
  localparam logic [32:0] LO = {1'b0, RAM_BASE};
  localparam logic [32:0] HI = {1'b0, RAM_BASE} + 33'(RAM_WORDS * 4);

  // R9: after an acceptance either the answer arrives or the unit is busy
  assert_accept_progress_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));

  // R9: response is a single-cycle pulse
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7: external port never carries a RAM-window address
  assert_ext_outside_window_R7: assert property (@(posedge clk) disable iff (rst)
    ext_req_valid |-> !(({1'b0, ext_req_addr} >= LO) && ({1'b0, ext_req_addr} < HI)));

  // R8: external request held stable until accepted
  assert_ext_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_req_valid && !ext_req_ready) |=>
      (ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_write)));

  // R10: exceptions carry no data
  assert_exc_no_data_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> (rsp_rdata == 32'd0));

  // R10: cause zero without exception
  assert_cause_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_exc) |-> (rsp_cause == 4'd0));

  // R4: illegal load code wins regardless of address
  assert_illegal_first_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_store && (req_funct3 == 3'b111)) |=>
      (rsp_valid && rsp_exc && (rsp_cause == 4'd2)));

  // R2: only defined cause codes appear
  assert_cause_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |->
      (rsp_cause == 4'd2 || rsp_cause == 4'd4 || rsp_cause == 4'd5 ||
       rsp_cause == 4'd6 || rsp_cause == 4'd7));
endmodule

bind lsu_unit lsu_unit_sva #(.RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_store     (req_store),
  .req_funct3    (req_funct3),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .rsp_exc       (rsp_exc),
  .rsp_cause     (rsp_cause),
  .ext_req_valid (ext_req_valid),
  .ext_req_ready (ext_req_ready),
  .ext_req_write (ext_req_write),
  .ext_req_addr  (ext_req_addr)
);

// File: tb/lsu_unit_tb.sv
`timescale 1ns/1ps
module lsu_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [2:0]  req_funct3 = 3'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_exc;
  logic [31:0] rsp_rdata, boot_pc;
  logic [3:0]  rsp_cause;
  logic        ext_req_valid, ext_req_write;
  logic [31:0] ext_req_addr, ext_req_wdata;
  logic [3:0]  ext_req_be;
  logic        ext_req_ready = 1'b0, ext_rsp_valid = 1'b0, ext_rsp_err = 1'b0;
  logic [31:0] ext_rsp_rdata = '0;

  int checks = 0, fails = 0, ext_cnt = 0;
  bit done = 0;
  logic [31:0] ext_mem [64];

  always #4 clk = ~clk;

  lsu_unit u_dut (.*);

  // external map: 0x8000_0000..0x8000_00FF backed, >= 0x9000_0000 refused,
  // everything else answers with a tag pattern
  always @(posedge clk) begin
    if (rst) begin
      ext_req_ready <= 1'b0;
      ext_rsp_valid <= 1'b0;
    end else begin
      ext_rsp_valid <= 1'b0;
      ext_req_ready <= ext_req_valid && !ext_req_ready;
      if (ext_req_valid && ext_req_ready) begin
        ext_cnt <= ext_cnt + 1;
        ext_rsp_valid <= 1'b1;
        ext_rsp_err   <= (ext_req_addr >= 32'h9000_0000);
        ext_rsp_rdata <= 32'hA5A5_0000 | {16'd0, ext_req_addr[15:0]};
        if (ext_req_addr[31:8] == 24'h800000) begin
          ext_rsp_rdata <= ext_mem[ext_req_addr[7:2]];
          if (ext_req_write)
            for (int b = 0; b < 4; b++)
              if (ext_req_be[b]) ext_mem[ext_req_addr[7:2]][b*8 +: 8] <= ext_req_wdata[b*8 +: 8];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [2:0] f3, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output logic ex,
                        output logic [3:0] ca, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_funct3 = f3; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; ex = rsp_exc; ca = rsp_cause;
  endtask

  task automatic expect_ok(input string tag, input logic st, input logic [2:0] f3,
                           input logic [31:0] a, input logic [31:0] d, input logic [31:0] exp);
    logic [31:0] rd; logic ex; logic [3:0] ca; int lat;
    access(st, f3, a, d, rd, ex, ca, lat);
    chk(!ex && rd == exp, tag, rd, exp);
  endtask

  task automatic expect_exc(input string tag, input logic st, input logic [2:0] f3,
                            input logic [31:0] a, input logic [3:0] cause);
    logic [31:0] rd; logic ex; logic [3:0] ca; int lat;
    access(st, f3, a, 32'hFFFF_FFFF, rd, ex, ca, lat);
    chk(ex && ca == cause && rd == 0, tag, {28'd0, ca}, {28'd0, cause});
  endtask

  task automatic t_reset;
    chk(req_ready && !rsp_valid && !ext_req_valid, "R1 reset outputs",
        {29'd0, req_ready, rsp_valid, ext_req_valid}, 32'h4);
    chk(boot_pc == 32'h40, "R1 boot_pc", boot_pc, 32'h40);
  endtask

  task automatic t_ram_latency;
    logic [31:0] rd; logic ex; logic [3:0] ca; int lat; int c0;
    c0 = ext_cnt;
    access(1'b1, 3'b010, 32'h100, 32'h89AB_CDEF, rd, ex, ca, lat);
    chk(lat == 1 && !ex, "R7 RAM store latency", lat, 1);
    access(1'b0, 3'b010, 32'h100, 0, rd, ex, ca, lat);
    chk(lat == 2 && rd == 32'h89AB_CDEF, "R7 RAM load latency/data", rd, 32'h89AB_CDEF);
    chk(ext_cnt == c0, "R7 no external traffic for RAM", ext_cnt, c0);
  endtask

  task automatic t_extract;
    expect_ok("R5 lb lane1 sign",   1'b0, 3'b000, 32'h101, 0, 32'hFFFF_FFCD);
    expect_ok("R5 lbu lane1 zero",  1'b0, 3'b100, 32'h101, 0, 32'h0000_00CD);
    expect_ok("R5 lb lane3",        1'b0, 3'b000, 32'h103, 0, 32'hFFFF_FF89);
    expect_ok("R5 lh upper sign",   1'b0, 3'b001, 32'h102, 0, 32'hFFFF_89AB);
    expect_ok("R5 lhu upper zero",  1'b0, 3'b101, 32'h102, 0, 32'h0000_89AB);
    expect_ok("R5 lh lower sign",   1'b0, 3'b001, 32'h100, 0, 32'hFFFF_CDEF);
    expect_ok("R5 lbu lane0",       1'b0, 3'b100, 32'h100, 0, 32'h0000_00EF);
  endtask

  task automatic t_merge;
    expect_ok("R6 sb lane2",     1'b1, 3'b000, 32'h102, 32'h0000_0055, 0);
    expect_ok("R6 sb readback",  1'b0, 3'b010, 32'h100, 0, 32'h8955_CDEF);
    expect_ok("R6 sh low",       1'b1, 3'b001, 32'h100, 32'hFFFF_1234, 0);
    expect_ok("R6 sh low rb",    1'b0, 3'b010, 32'h100, 0, 32'h8955_1234);
    expect_ok("R6 sh high",      1'b1, 3'b001, 32'h102, 32'h0000_BEEF, 0);
    expect_ok("R6 sh high rb",   1'b0, 3'b010, 32'h100, 0, 32'hBEEF_1234);
    expect_ok("R5 positive lb",  1'b0, 3'b000, 32'h100, 0, 32'h0000_0034);
  endtask

  task automatic t_illegal;
    int c0;
    c0 = ext_cnt;
    expect_exc("R2 load f3=011", 1'b0, 3'b011, 32'h100, 4'd2);
    expect_exc("R2 load f3=110", 1'b0, 3'b110, 32'h100, 4'd2);
    expect_exc("R2 load f3=111", 1'b0, 3'b111, 32'h100, 4'd2);
    for (int f = 3; f < 8; f++)
      expect_exc("R2 store f3>010", 1'b1, 3'(f), 32'h100, 4'd2);
    expect_exc("R2 illegal store ext addr", 1'b1, 3'b100, 32'h8000_0000, 4'd2);
    expect_ok("R2 word unchanged", 1'b0, 3'b010, 32'h100, 0, 32'hBEEF_1234);
    chk(ext_cnt == c0, "R2 no external request", ext_cnt, c0);
  endtask

  task automatic t_misal;
    expect_exc("R3 lh odd",    1'b0, 3'b001, 32'h101, 4'd4);
    expect_exc("R3 lhu odd",   1'b0, 3'b101, 32'h103, 4'd4);
    expect_exc("R3 lw +2",     1'b0, 3'b010, 32'h102, 4'd4);
    expect_exc("R3 sw +1",     1'b1, 3'b010, 32'h101, 4'd6);
    expect_exc("R3 sh +3",     1'b1, 3'b001, 32'h103, 4'd6);
    expect_ok("R3 word unchanged", 1'b0, 3'b010, 32'h100, 0, 32'hBEEF_1234);
    expect_ok("R3 byte any lane ok", 1'b0, 3'b100, 32'h103, 0, 32'h0000_00BE);
  endtask

  task automatic t_priority;
    int c0;
    expect_exc("R4 illegal over misaligned load", 1'b0, 3'b111, 32'h101, 4'd2);
    expect_exc("R4 illegal over misaligned store", 1'b1, 3'b101, 32'h103, 4'd2);
    c0 = ext_cnt;
    expect_exc("R4 misaligned over fault load", 1'b0, 3'b010, 32'h9000_0002, 4'd4);
    expect_exc("R4 misaligned over fault store", 1'b1, 3'b001, 32'h9000_0001, 4'd6);
    chk(ext_cnt == c0, "R4 no external request", ext_cnt, c0);
  endtask

  task automatic t_external;
    int c0;
    c0 = ext_cnt;
    expect_ok("R8 ext sw",        1'b1, 3'b010, 32'h8000_0010, 32'hCAFE_F00D, 0);
    expect_ok("R8 ext lw",        1'b0, 3'b010, 32'h8000_0010, 0, 32'hCAFE_F00D);
    expect_ok("R8 ext sb lane1",  1'b1, 3'b000, 32'h8000_0011, 32'h0000_0077, 0);
    expect_ok("R8 ext lw merged", 1'b0, 3'b010, 32'h8000_0010, 0, 32'hCAFE_770D);
    expect_ok("R8 ext lb sign",   1'b0, 3'b000, 32'h8000_0013, 0, 32'hFFFF_FFCA);
    expect_exc("R8 ext load fault",  1'b0, 3'b010, 32'h9000_0000, 4'd5);
    expect_exc("R8 ext store fault", 1'b1, 3'b000, 32'h9000_0005, 4'd7);
    chk(ext_cnt == c0 + 7, "R8 external request count", ext_cnt, c0 + 7);
  endtask

  task automatic t_window_edge;
    int c0;
    c0 = ext_cnt;
    expect_ok("R7 top word store", 1'b1, 3'b010, 32'h3FC, 32'h1357_2468, 0);
    expect_ok("R7 top word load",  1'b0, 3'b010, 32'h3FC, 0, 32'h1357_2468);
    chk(ext_cnt == c0, "R7 top of window stays local", ext_cnt, c0);
    expect_ok("R7 first address past window", 1'b0, 3'b010, 32'h400, 0, 32'hA5A5_0400);
    chk(ext_cnt == c0 + 1, "R7 past window goes external", ext_cnt, c0 + 1);
  endtask

  task automatic t_busy;
    int pulses = 0; int lows = 0;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_funct3 = 3'b010; req_addr = 32'h8000_0010;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (rsp_valid) pulses++;
      if (!req_ready && !rsp_valid) lows++;
      @(negedge clk);
    end
    chk(pulses == 1, "R9 exactly one response pulse", pulses, 1);
    chk(lows >= 2, "R9 ready low while in flight", lows, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram_latency();
    t_extract();
    t_merge();
    t_illegal();
    t_misal();
    t_priority();
    t_external();
    t_window_edge();
    t_busy();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule